// File: doc/BRIEF.md
# I2C Master Bit-Timing Generator

This block turns single-bit bus commands into SCL and SDA waveforms for an I2C master. The commands are START, STOP, write-bit and read-bit. A START issued while the bus is already held becomes a repeated START. Every phase length is a fixed multiple of one timing unit of U = (T+1) system clocks, where T is the programmed timer period. Values of T below 2 are raised to 2, and T = 2 gives the fastest SCL. The SCL low time is 12 U and the SCL high time is 8 U. Each data change on SDA is placed 6 U into the SCL low time, which is the middle of that low period.

Commands arrive on a valid/ready port. A command transfers on a clock edge where `cmd_valid` and `cmd_ready` are both high. While a command is running, `cmd_ready` stays low and the caller holds its command. `cmd_ready` does not depend on `cmd_valid`. Completion is reported by a one-cycle `done` pulse, and `rd_bit` carries the sampled SDA value after a read. `done` has no back-pressure, so the consumer must take it in the cycle it appears.

Between bits, the block leaves SCL pulled low. After a STOP, both lines are released. The outputs are pull-low enables for open-drain pads.

Top module: `i2c_bit_timer`

## Requirements
- R1: After reset, `scl_oe` = 0, `sda_oe` = 0, `cmd_ready` = 1 and `done` = 0.
- R2: The op codes are START = 0, STOP = 1, WRITE = 2 and READ = 3. A START accepted while idle keeps both lines released for 8 U. It then pulls SDA at the edge 8 U after the accepting edge and pulls SCL at 20 U. `done` is high in the cycle after that 20 U edge.
- R3: U = max(T,2)+1 clocks. T is captured when a START is accepted from idle. Later changes to `tpr` have no effect on timing until the STOP of that transaction has completed.
- R4: WRITE holds the previous SDA level for 6 U. At 6 U it drives SDA to the bit (`sda_oe` = not `cmd_wbit`). It releases SCL at 12 U and pulls SCL again at 20 U, and SDA stays unchanged while SCL is released. `done` follows at 20 U.
- R5: READ releases SDA at 6 U and releases SCL at 12 U. It captures `sda_in` at the edge 16 U after acceptance, which is the middle of the high time. It pulls SCL at 20 U and presents the captured value on `rd_bit` with `done`.
- R6: STOP pulls SDA at 6 U, releases SCL at 12 U and releases SDA at 20 U. `done` follows, and the block returns to idle.
- R7: START while the bus is held is a repeated START. It releases SDA at 6 U and SCL at 12 U. After 12 U of setup it pulls SDA at 24 U, then pulls SCL at 36 U, and `done` follows.
- R8: `cmd_ready` is high only when the block is idle or holding SCL low between bits. It is high in every cycle where `done` is high, so the next command can transfer in that same cycle.
- R9: A STOP, WRITE or READ accepted while idle leaves both lines released. It raises `done` in the next cycle.
- R10: `scl_oe` and `sda_oe` set to 1 mean pull the line low, and 0 means release it. Both are 0 whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tpr | input | TPR_W | Timer period T, captured at START |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Command ready |
| cmd_op | input | 2 | Op code: 0 START, 1 STOP, 2 WRITE, 3 READ |
| cmd_wbit | input | 1 | Bit value for WRITE |
| done | output | 1 | One-cycle completion pulse |
| rd_bit | output | 1 | SDA value captured by the last READ |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The `done` pulse of one command and the acceptance of the next command can fall in the same cycle. To provoke this, the driver raises `cmd_valid` for the next command before the current one finishes, so the transfer happens in the very cycle `done` is high. The scoreboard judges the result by the exact cycle of each `done`. It also checks every later line transition at offsets counted from that acceptance, so a one-cycle slip or a lost command shows up as a failed check.

// File: rtl/i2cbt_pkg.sv
package i2cbt_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,   // bus free, both released
    ST_FREE,   // bus-free wait before START
    ST_SHOLD,  // SDA low, SCL high: start hold
    ST_LOW1,   // first half of SCL low
    ST_LOW2,   // second half of SCL low
    ST_HIGH,   // SCL released
    ST_HOLD    // SCL held low, waiting for a command
  } st_e;

  localparam int UNIT_W = 4;
  localparam logic [UNIT_W-1:0] FREE_UNITS  = 4'd8;
  localparam logic [UNIT_W-1:0] SHOLD_UNITS = 4'd12;
  localparam logic [UNIT_W-1:0] HALF_LOW    = 4'd6;
  localparam logic [UNIT_W-1:0] HIGH_UNITS  = 4'd8;
  localparam logic [UNIT_W-1:0] RS_SETUP    = 4'd12;
  localparam logic [UNIT_W-1:0] SAMPLE_AT   = 4'd4;
  localparam int TPR_MIN = 2;
endpackage

// File: rtl/i2cbt_unit_timer.sv
module i2cbt_unit_timer
  import i2cbt_pkg::*;
#(
  parameter int TPR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [TPR_W-1:0]  tpr_q,
  input  logic [UNIT_W-1:0] len,
  output logic              tick,
  output logic [UNIT_W-1:0] ucnt,
  output logic              phase_end
);
  logic [TPR_W-1:0] cnt;

  assign tick      = run && (cnt == tpr_q);
  assign phase_end = tick && (ucnt == len - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      ucnt <= '0;
    end else if (!run || phase_end) begin
      cnt  <= '0;
      ucnt <= '0;
    end else if (tick) begin
      cnt  <= '0;
      ucnt <= ucnt + 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3: the clock divider never runs past the captured period
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= tpr_q));
endmodule

// File: rtl/i2cbt_seq.sv
module i2cbt_seq
  import i2cbt_pkg::*;
#(
  parameter int TPR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TPR_W-1:0]  tpr,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic              cmd_wbit,
  output logic              done,
  output logic              rd_bit,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              run,
  output logic [TPR_W-1:0]  tpr_q,
  output logic [UNIT_W-1:0] len,
  input  logic              tick,
  input  logic [UNIT_W-1:0] ucnt,
  input  logic              phase_end
);
  localparam logic [TPR_W-1:0] TMIN = TPR_W'(TPR_MIN);

  st_e  state;
  op_e  op_q;
  logic wbit_q;
  logic scl_lo, sda_lo;
  logic accept;

  assign cmd_ready = (state == ST_IDLE) || (state == ST_HOLD);
  assign accept    = cmd_valid && cmd_ready;
  assign run       = !cmd_ready;
  assign scl_oe    = scl_lo;
  assign sda_oe    = sda_lo;

  always_comb begin
    case (state)
      ST_FREE:  len = FREE_UNITS;
      ST_SHOLD: len = SHOLD_UNITS;
      ST_LOW1:  len = HALF_LOW;
      ST_LOW2:  len = HALF_LOW;
      ST_HIGH:  len = (op_q == OP_START) ? RS_SETUP : HIGH_UNITS;
      default:  len = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      op_q   <= OP_START;
      wbit_q <= 1'b0;
      scl_lo <= 1'b0;
      sda_lo <= 1'b0;
      tpr_q  <= TMIN;
      done   <= 1'b0;
      rd_bit <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          if (op_e'(cmd_op) == OP_START) begin
            tpr_q <= (tpr < TMIN) ? TMIN : tpr;
            op_q  <= OP_START;
            state <= ST_FREE;
          end else begin
            done <= 1'b1;
          end
        end
        ST_HOLD: if (accept) begin
          op_q   <= op_e'(cmd_op);
          wbit_q <= cmd_wbit;
          state  <= ST_LOW1;
        end
        ST_FREE: if (phase_end) begin
          sda_lo <= 1'b1;
          state  <= ST_SHOLD;
        end
        ST_SHOLD: if (phase_end) begin
          scl_lo <= 1'b1;
          done   <= 1'b1;
          state  <= ST_HOLD;
        end
        ST_LOW1: if (phase_end) begin
          case (op_q)
            OP_WRITE: sda_lo <= !wbit_q;
            OP_STOP:  sda_lo <= 1'b1;
            default:  sda_lo <= 1'b0;
          endcase
          state <= ST_LOW2;
        end
        ST_LOW2: if (phase_end) begin
          scl_lo <= 1'b0;
          state  <= ST_HIGH;
        end
        ST_HIGH: begin
          if (op_q == OP_READ && tick && ucnt == SAMPLE_AT - 1'b1)
            rd_bit <= sda_in;
          if (phase_end) begin
            case (op_q)
              OP_STOP: begin
                sda_lo <= 1'b0;
                done   <= 1'b1;
                state  <= ST_IDLE;
              end
              OP_START: begin
                sda_lo <= 1'b1;
                state  <= ST_SHOLD;
              end
              default: begin
                scl_lo <= 1'b1;
                done   <= 1'b1;
                state  <= ST_HOLD;
              end
            endcase
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: captured period holds for the whole transaction
  p_tpr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(tpr_q));
  // R3: captured period never below the minimum
  p_tpr_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |-> (tpr_q >= TMIN));
  // R4: data line frozen while SCL is released during a data bit
  p_sda_stable_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HIGH && $past(state) == ST_HIGH &&
     (op_q == OP_WRITE || op_q == OP_READ)) |-> $stable(sda_lo));
  // R10: idle bus is fully released
  p_idle_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> (!scl_lo && !sda_lo));
  // R8: between bits the clock line is held low
  p_hold_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD) |-> scl_lo);
  // R8: completion always coincides with readiness
  p_done_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);
endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer
  import i2cbt_pkg::*;
#(
  parameter int TPR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TPR_W-1:0] tpr,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic             cmd_wbit,
  output logic             done,
  output logic             rd_bit,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe
);
  logic              run, tick, phase_end;
  logic [TPR_W-1:0]  tpr_q;
  logic [UNIT_W-1:0] len, ucnt;

  i2cbt_seq #(.TPR_W(TPR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .tpr(tpr),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_wbit(cmd_wbit),
    .done(done), .rd_bit(rd_bit), .sda_in(sda_in),
    .scl_oe(scl_oe), .sda_oe(sda_oe),
    .run(run), .tpr_q(tpr_q), .len(len),
    .tick(tick), .ucnt(ucnt), .phase_end(phase_end)
  );

  i2cbt_unit_timer #(.TPR_W(TPR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .tpr_q(tpr_q), .len(len),
    .tick(tick), .ucnt(ucnt), .phase_end(phase_end)
  );
endmodule

// File: tb/i2c_bit_timer_bench.sv
module i2c_bit_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] tpr = 8'd2;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [1:0] cmd_op = 2'd0;
  logic       cmd_wbit = 1'b0;
  logic       done, rd_bit, scl_oe, sda_oe;
  logic       sda_in = 1'b1;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int acc = 0;
  int u = 3;
  logic psda = 1'b0;

  int   q_cyc[$];
  logic q_rd[$];
  logic q_chk[$];
  string q_req[$];

  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  i2c_bit_timer u_i2c_bit_timer (
    .clk(clk), .rst_n(rst_n), .tpr(tpr),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_wbit(cmd_wbit),
    .done(done), .rd_bit(rd_bit), .sda_in(sda_in),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic line_at(int t, logic es, logic ed, string req);
    while (cyc < t) @(negedge clk);
    chk({req, " scl_oe"}, int'(scl_oe), int'(es));
    chk({req, " sda_oe"}, int'(sda_oe), int'(ed));
  endtask

  task automatic push(int c, logic rd, logic use_rd, string req);
    q_cyc.push_back(c);
    q_rd.push_back(rd);
    q_chk.push_back(use_rd);
    q_req.push_back(req);
  endtask

  // Driver: valid raised early so transfer can happen in the done cycle
  task automatic issue(logic [1:0] op, logic b);
    cmd_op = op;
    cmd_wbit = b;
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    acc = cyc;
  endtask

  task automatic do_start_idle();
    issue(2'd0, 1'b0);
    push(acc + 20*u, 1'b0, 1'b0, "R2");
    chk("R8 busy ready", int'(cmd_ready), 0);
    line_at(acc + 8*u - 1, 1'b0, 1'b0, "R2");
    line_at(acc + 8*u,     1'b0, 1'b1, "R2");
    line_at(acc + 20*u - 1, 1'b0, 1'b1, "R2");
    line_at(acc + 20*u,    1'b1, 1'b1, "R2");
    psda = 1'b1;
  endtask

  task automatic do_write(logic b);
    issue(2'd2, b);
    push(acc + 20*u, 1'b0, 1'b0, "R4");
    line_at(acc + 6*u - 1, 1'b1, psda, "R4");
    line_at(acc + 6*u,     1'b1, !b, "R4");
    line_at(acc + 12*u - 1, 1'b1, !b, "R4");
    line_at(acc + 12*u,    1'b0, !b, "R4");
    line_at(acc + 20*u - 1, 1'b0, !b, "R4");
    line_at(acc + 20*u,    1'b1, !b, "R4");
    psda = !b;
  endtask

  task automatic do_read(logic v);
    sda_in = !v;
    issue(2'd3, 1'b0);
    push(acc + 20*u, v, 1'b1, "R5");
    line_at(acc + 6*u - 1, 1'b1, psda, "R5");
    line_at(acc + 6*u,     1'b1, 1'b0, "R5");
    line_at(acc + 12*u,    1'b0, 1'b0, "R5");
    while (cyc < acc + 16*u - 1) @(negedge clk);
    sda_in = v;
    @(negedge clk);
    sda_in = !v;
    line_at(acc + 20*u - 1, 1'b0, 1'b0, "R5");
    line_at(acc + 20*u,    1'b1, 1'b0, "R5");
    sda_in = 1'b1;
    psda = 1'b0;
  endtask

  task automatic do_stop();
    issue(2'd1, 1'b0);
    push(acc + 20*u, 1'b0, 1'b0, "R6");
    line_at(acc + 6*u - 1, 1'b1, psda, "R6");
    line_at(acc + 6*u,     1'b1, 1'b1, "R6");
    line_at(acc + 12*u - 1, 1'b1, 1'b1, "R6");
    line_at(acc + 12*u,    1'b0, 1'b1, "R6");
    line_at(acc + 20*u - 1, 1'b0, 1'b1, "R6");
    line_at(acc + 20*u,    1'b0, 1'b0, "R6");
    psda = 1'b0;
  endtask

  task automatic do_restart();
    issue(2'd0, 1'b0);
    push(acc + 36*u, 1'b0, 1'b0, "R7");
    line_at(acc + 6*u - 1, 1'b1, psda, "R7");
    line_at(acc + 6*u,     1'b1, 1'b0, "R7");
    line_at(acc + 12*u,    1'b0, 1'b0, "R7");
    line_at(acc + 24*u - 1, 1'b0, 1'b0, "R7");
    line_at(acc + 24*u,    1'b0, 1'b1, "R7");
    line_at(acc + 36*u - 1, 1'b0, 1'b1, "R7");
    line_at(acc + 36*u,    1'b1, 1'b1, "R7");
    psda = 1'b1;
  endtask

  // Monitor: pops the scoreboard on every done pulse
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && done) begin
        if (q_cyc.size() == 0) begin
          chk("R8 unexpected done", 1, 0);
        end else begin
          int c;
          logic r, k;
          string rq;
          c = q_cyc.pop_front();
          r = q_rd.pop_front();
          k = q_chk.pop_front();
          rq = q_req.pop_front();
          chk({rq, " done cycle"}, cyc, c);
          chk("R8 ready with done", int'(cmd_ready), 1);
          if (k) chk({rq, " rd_bit"}, int'(rd_bit), int'(r));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 / R10: reset state
    chk("R1 scl_oe", int'(scl_oe), 0);
    chk("R1 sda_oe", int'(sda_oe), 0);
    chk("R1 ready", int'(cmd_ready), 1);
    chk("R1 done", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: data command while idle completes at once, lines untouched
    issue(2'd2, 1'b0);
    push(acc, 1'b0, 1'b0, "R9");
    chk("R9 scl_oe", int'(scl_oe), 0);
    chk("R9 sda_oe", int'(sda_oe), 0);
    @(negedge clk);
    chk("R10 idle scl_oe", int'(scl_oe), 0);

    // Transaction at T=2; tpr changed mid-transaction must not matter (R3)
    u = 3;
    do_start_idle();
    tpr = 8'd9;
    do_write(1'b1);
    do_write(1'b0);
    do_read(1'b1);
    do_read(1'b0);
    do_restart();
    do_write(1'b0);
    do_stop();

    // R3: T below minimum behaves as T=2
    tpr = 8'd0;
    u = 3;
    do_start_idle();
    do_read(1'b1);
    do_stop();

    // R3: slower setting stretches every phase
    tpr = 8'd5;
    u = 6;
    do_start_idle();
    do_write(1'b1);
    do_stop();

    repeat (5) @(negedge clk);
    chk("R8 scoreboard drained", q_cyc.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule